// File: doc/BRIEF.md
# Up/Down PWM Timer with Direction-Qualified Compare

This block is a single-channel timer that counts on every clock while enabled and drives one PWM output. It runs in one of four counting modes. In edge mode it counts in one direction, chosen by a control bit, and wraps at the reload value. In the three center modes it counts up and down in a triangle. A compare channel drives the PWM level and sets a sticky match flag. In each center mode, only certain count directions may set that flag.

Software programs the block through a plain register port with a write strobe, an address and write data. Reads are combinational, so `reg_rdata` shows the register selected by `reg_addr` in the same cycle. The compare value and the reload value each have a shadow register. When preload is enabled, a new value waits in the shadow register and moves to the active copy only at an update event. A lock level can freeze the preload settings. The port has no data stream, so it has no valid/ready handshake. All writes complete in one cycle.

Top module: `updown_pwm_timer`

## Requirements
- R1: After reset the count is 0, both flags are 0, the control register reads 0, the reload register reads all ones, the compare register reads 0 and `pwm_out` is 0.
- R2: Edge mode is alignment code 00. When the direction bit is 0, the counter counts up; when the count reaches the reload value or above it, the next value is 0. When the direction bit is 1, the counter counts down; from 0 it loads the reload value. Each wrap is an update event.
- R3: In alignment codes 01, 10 and 11 the counter counts 0 up to the reload value, then back down to 0, and repeats. Each turnaround, at the top and at 0, is an update event. With a reload of 0 the count stays at 0 and every cycle is an update event.
- R4: A compare match occurs when the enabled counter equals the active compare value. The count value equal to the reload value belongs to the up phase. The value 0 belongs to the down phase, except for the first 0 after a reset or a reset-count command, which belongs to the up phase. Which matches set the compare flag depends on the alignment code: code 00 sets it on every match, code 01 only in the down phase, code 10 only in the up phase, and code 11 in both phases.
- R5: With compare preload off, a compare write changes the active compare value at the next clock. With compare preload on, the write goes only to the shadow register, and the shadow value moves to the active register at the next update event.
- R6: The reload register follows the same preload rule as R5, under its own preload bit.
- R7: `pwm_out` equals (count < active compare) XOR polarity. A compare of 0 therefore keeps the output inactive. A compare above the reload value keeps it active.
- R8: The update flag and the compare flag stay set until they are cleared. A write to address 4 clears flag bit 0 (update) and flag bit 1 (compare) where the data bit is 1. When a set and a clear happen in the same cycle, the set wins.
- R9: Writing 1 to bit 0 of address 5 forces the count to 0 and returns the center direction to up. This command takes priority over counting.
- R10: While the enable bit currently stored is 1, a control write leaves the alignment field unchanged.
- R11: While the stored lock level is 3, a control write leaves both preload bits and the lock field unchanged.
- R12: The register map is: address 0 control, address 1 reload (reads the shadow), address 2 compare (reads the shadow), address 3 count (read only), address 4 flags (read value {compare, update}), address 5 command. The control bits are: 0 enable, 1 count down, 3:2 alignment, 4 compare preload, 5 reload preload, 6 polarity, 8:7 lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM output after polarity |
| upd_flag | output | 1 | Sticky update-event flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
A wrong count or a lost direction state shows up on the count read-back and on `pwm_out` in the very next cycle. If the phase register is wrong, the compare flag either rises on a match that should be ignored or stays low on one that should count; this becomes visible within one counting period. A shadow transfer that happens too early or too late moves the PWM edge for one period. Because the bench reference model tracks the count, the phases, the shadow registers and the flags, a fault is caught on the first clock where the port values differ.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ALN_EDGE  = 2'b00,
    ALN_DOWNQ = 2'b01,
    ALN_UPQ   = 2'b10,
    ALN_BOTH  = 2'b11
  } align_e;

  localparam int ADDR_W    = 3;
  localparam int CTRL_BITS = 9;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP    = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd5;

  // Packed MSB first: lock[8:7] pol[6] rpe[5] cpe[4] align[3:2] dir_dn[1] en[0]
  typedef struct packed {
    logic [1:0] lock;
    logic       pol;
    logic       rpe;
    logic       cpe;
    align_e     align;
    logic       dir_dn;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/tmr_shadow_reg.sv
module tmr_shadow_reg #(
  parameter int           W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         pre_en,
  input  logic         load,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RST_VAL;
      active <= RST_VAL;
    end else begin
      if (wr) shadow <= wdata;
      if (wr && !pre_en) active <= wdata;
      else if (load && pre_en) active <= shadow;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              upd_evt,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  arr_sh,
  output logic [CNT_W-1:0]  arr_act,
  output logic [CNT_W-1:0]  cmp_sh,
  output logic [CNT_W-1:0]  cmp_act,
  output logic              cnt_clr,
  output logic [1:0]        flag_clr
);
  localparam logic [CNT_W-1:0] ARR_RST = '1;
  localparam logic [CNT_W-1:0] CMP_RST = '0;

  logic  wr_ctrl, wr_arr, wr_cmp;
  ctrl_t ctrl_req, ctrl_nx;

  assign wr_ctrl  = we && (addr == A_CTRL);
  assign wr_arr   = we && (addr == A_RELOAD);
  assign wr_cmp   = we && (addr == A_CMP);
  assign cnt_clr  = we && (addr == A_CMD) && wdata[0];
  assign flag_clr = (we && (addr == A_FLAGS)) ? wdata[1:0] : 2'b00;
  assign ctrl_req = ctrl_t'(wdata[CTRL_BITS-1:0]);

  always_comb begin
    ctrl_nx = ctrl_req;
    if (ctrl.en) ctrl_nx.align = ctrl.align;
    if (ctrl.lock == 2'd3) begin
      ctrl_nx.cpe  = ctrl.cpe;
      ctrl_nx.rpe  = ctrl.rpe;
      ctrl_nx.lock = ctrl.lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (wr_ctrl) ctrl <= ctrl_nx;
  end

  tmr_shadow_reg #(.W(CNT_W), .RST_VAL(ARR_RST)) i_arr (
    .clk(clk), .rst_n(rst_n), .wr(wr_arr), .wdata(wdata),
    .pre_en(ctrl.rpe), .load(upd_evt), .shadow(arr_sh), .active(arr_act)
  );

  tmr_shadow_reg #(.W(CNT_W), .RST_VAL(CMP_RST)) i_cmp (
    .clk(clk), .rst_n(rst_n), .wr(wr_cmp), .wdata(wdata),
    .pre_en(ctrl.cpe), .load(upd_evt), .shadow(cmp_sh), .active(cmp_act)
  );

  logic unused_wdata;
  assign unused_wdata = ^wdata[CNT_W-1:CTRL_BITS];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             dir_dn,
  input  align_e           align,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             phase_dn,
  output logic             upd_evt
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_nx;
  logic             dn_nx;
  logic             at_top, at_bot;

  assign at_top = (cnt >= top);
  assign at_bot = (cnt == ZERO);

  always_comb begin
    cnt_nx  = cnt;
    dn_nx   = phase_dn;
    upd_evt = 1'b0;
    if (clr) begin
      cnt_nx = ZERO;
      dn_nx  = 1'b0;
    end else if (run) begin
      if (align == ALN_EDGE) begin
        if (!dir_dn) begin
          if (at_top) begin
            cnt_nx  = ZERO;
            upd_evt = 1'b1;
          end else begin
            cnt_nx = cnt + ONE;
          end
        end else begin
          if (at_bot) begin
            cnt_nx  = top;
            upd_evt = 1'b1;
          end else begin
            cnt_nx = cnt - ONE;
          end
        end
      end else if (!phase_dn) begin
        if (at_top) begin
          upd_evt = 1'b1;
          if (top != ZERO) begin
            cnt_nx = cnt - ONE;
            dn_nx  = 1'b1;
          end
        end else begin
          cnt_nx = cnt + ONE;
        end
      end else begin
        if (at_bot) begin
          upd_evt = 1'b1;
          dn_nx   = 1'b0;
          cnt_nx  = (top == ZERO) ? ZERO : ONE;
        end else begin
          cnt_nx = cnt - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= ZERO;
      phase_dn <= 1'b0;
    end else begin
      cnt      <= cnt_nx;
      phase_dn <= dn_nx;
    end
  end
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             phase_dn,
  input  align_e           align,
  input  logic             pol,
  input  logic             upd_evt,
  input  logic [1:0]       flag_clr,
  output logic             pwm_out,
  output logic             upd_flag,
  output logic             cmp_flag
);
  logic dir_ok, hit;

  always_comb begin
    unique case (align)
      ALN_DOWNQ: dir_ok = phase_dn;
      ALN_UPQ:   dir_ok = !phase_dn;
      default:   dir_ok = 1'b1;
    endcase
  end

  assign hit     = run && (cnt == cmp) && dir_ok;
  assign pwm_out = (cnt < cmp) ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      upd_flag <= upd_evt || (upd_flag && !flag_clr[0]);
      cmp_flag <= hit || (cmp_flag && !flag_clr[1]);
    end
  end
endmodule

// File: rtl/updown_pwm_timer.sv
module updown_pwm_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              pwm_out,
  output logic              upd_flag,
  output logic              cmp_flag
);
  localparam int CTRL_PAD = CNT_W - CTRL_BITS;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] arr_sh, arr_act, cmp_sh, cmp_act, cnt;
  logic             cnt_clr, upd_evt, phase_dn, run;
  logic [1:0]       flag_clr;

  assign run = ctrl.en && !cnt_clr;

  tmr_regs #(.CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .upd_evt(upd_evt), .ctrl(ctrl), .arr_sh(arr_sh), .arr_act(arr_act),
    .cmp_sh(cmp_sh), .cmp_act(cmp_act), .cnt_clr(cnt_clr), .flag_clr(flag_clr)
  );

  tmr_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.en), .clr(cnt_clr), .dir_dn(ctrl.dir_dn),
    .align(ctrl.align), .top(arr_act), .cnt(cnt), .phase_dn(phase_dn), .upd_evt(upd_evt)
  );

  tmr_compare #(.CNT_W(CNT_W)) i_cmp (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .cmp(cmp_act),
    .phase_dn(phase_dn), .align(ctrl.align), .pol(ctrl.pol), .upd_evt(upd_evt),
    .flag_clr(flag_clr), .pwm_out(pwm_out), .upd_flag(upd_flag), .cmp_flag(cmp_flag)
  );

  always_comb begin
    unique case (reg_addr)
      A_CTRL:   reg_rdata = {{CTRL_PAD{1'b0}}, ctrl};
      A_RELOAD: reg_rdata = arr_sh;
      A_CMP:    reg_rdata = cmp_sh;
      A_COUNT:  reg_rdata = cnt;
      A_FLAGS:  reg_rdata = {{(CNT_W-2){1'b0}}, cmp_flag, upd_flag};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CNT_W-1:0]  reg_wdata,
  input logic              pwm_out,
  input logic              upd_flag,
  input logic              cmp_flag,
  input logic [CNT_W-1:0]  cnt,
  input logic              phase_dn,
  input ctrl_t             ctrl,
  input logic [CNT_W-1:0]  cmp_act,
  input logic [CNT_W-1:0]  arr_act
);
  logic cmd_hit, uf_clr;
  assign cmd_hit = reg_we && (reg_addr == A_CMD) && reg_wdata[0];
  assign uf_clr  = reg_we && (reg_addr == A_FLAGS) && reg_wdata[0];

  // R9
  cnt_zero_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> (cnt == '0));

  // R8
  upd_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_flag && !uf_clr) |=> upd_flag);

  // R7
  cmp_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '0) |-> (pwm_out == ctrl.pol));

  // R7
  cmp_above_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_act > arr_act) && (cnt <= arr_act)) |-> (pwm_out != ctrl.pol));

  // R4
  down_only_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl.align == ALN_DOWNQ) && $rose(cmp_flag)) |-> $past(phase_dn));

  // R4
  up_only_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl.align == ALN_UPQ) && $rose(cmp_flag)) |-> !$past(phase_dn));

  // R10
  align_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.en |=> (ctrl.align == $past(ctrl.align)));

  // R11
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.lock == 2'd3) |=> ((ctrl.cpe == $past(ctrl.cpe)) && (ctrl.rpe == $past(ctrl.rpe))
                             && (ctrl.lock == 2'd3)));

  // R3
  center_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && (ctrl.align != ALN_EDGE) && (arr_act != '0) && !cmd_hit) |=> (cnt != $past(cnt)));
endmodule

bind updown_pwm_timer tmr_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .pwm_out(pwm_out), .upd_flag(upd_flag), .cmp_flag(cmp_flag), .cnt(cnt),
  .phase_dn(phase_dn), .ctrl(ctrl), .cmp_act(cmp_act), .arr_act(arr_act)
);

// File: tb/test_updown_pwm_timer.sv
`timescale 1ns/1ps
module test_updown_pwm_timer;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = 3'd3;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         pwm_out, upd_flag, cmp_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  updown_pwm_timer #(.CNT_W(W)) i_updown_pwm_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out),
    .upd_flag(upd_flag), .cmp_flag(cmp_flag)
  );

  // behavioural reference state
  int m_cnt, m_arr, m_arr_sh, m_cmp, m_cmp_sh, m_align, m_lock;
  bit m_en, m_dir, m_cpe, m_rpe, m_pol, m_down, m_uf, m_cf;
  int n_cnt;
  bit n_down, upd, hit, qual, clr;
  int w;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_arr = 65535; m_arr_sh = 65535; m_cmp = 0; m_cmp_sh = 0;
      m_align = 0; m_lock = 0; m_en = 0; m_dir = 0; m_cpe = 0; m_rpe = 0;
      m_pol = 0; m_down = 0; m_uf = 0; m_cf = 0;
    end else begin
      w = int'(reg_wdata);
      clr = reg_we && reg_addr == 3'd5 && w[0];
      upd = 0; hit = 0; n_cnt = m_cnt; n_down = m_down;
      if (m_en && !clr) begin
        qual = (m_align == 1) ? m_down : (m_align == 2) ? !m_down : 1'b1;
        hit = (m_cnt == m_cmp) && qual;
        if (m_align == 0) begin
          if (!m_dir) begin
            if (m_cnt >= m_arr) begin n_cnt = 0; upd = 1; end else n_cnt = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin n_cnt = m_arr; upd = 1; end else n_cnt = m_cnt - 1;
          end
        end else if (!m_down) begin
          if (m_cnt >= m_arr) begin
            upd = 1;
            if (m_arr != 0) begin n_cnt = m_cnt - 1; n_down = 1; end
          end else n_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin upd = 1; n_down = 0; n_cnt = (m_arr == 0) ? 0 : 1; end
          else n_cnt = m_cnt - 1;
        end
      end
      if (clr) begin n_cnt = 0; n_down = 0; end
      if (reg_we && reg_addr == 3'd4) begin
        m_uf = upd || (m_uf && !w[0]);
        m_cf = hit || (m_cf && !w[1]);
      end else begin
        m_uf = upd || m_uf;
        m_cf = hit || m_cf;
      end
      if (reg_we && reg_addr == 3'd1 && !m_rpe) m_arr = w;
      else if (upd && m_rpe) m_arr = m_arr_sh;
      if (reg_we && reg_addr == 3'd1) m_arr_sh = w;
      if (reg_we && reg_addr == 3'd2 && !m_cpe) m_cmp = w;
      else if (upd && m_cpe) m_cmp = m_cmp_sh;
      if (reg_we && reg_addr == 3'd2) m_cmp_sh = w;
      if (reg_we && reg_addr == 3'd0) begin
        if (!m_en) m_align = (w >> 2) & 3;
        if (m_lock != 3) begin
          m_cpe = w[4]; m_rpe = w[5]; m_lock = (w >> 7) & 3;
        end
        m_en = w[0]; m_dir = w[1]; m_pol = w[6];
      end
      m_cnt = n_cnt; m_down = n_down;
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0: return int'(m_en) | (int'(m_dir) << 1) | (m_align << 2) | (int'(m_cpe) << 4)
              | (int'(m_rpe) << 5) | (int'(m_pol) << 6) | (m_lock << 7);
      1: return m_arr_sh;
      2: return m_cmp_sh;
      3: return m_cnt;
      4: return (int'(m_cf) << 1) | int'(m_uf);
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7 pwm level", int'(pwm_out), int'((m_cnt < m_cmp) ^ m_pol));
      check("R8 update flag", int'(upd_flag), int'(m_uf));
      check("R4 compare flag", int'(cmp_flag), int'(m_cf));
      if (reg_addr == 3'd3)
        check(m_align == 0 ? "R2 count" : "R3 count", int'(reg_rdata), m_cnt);
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = W'(d);
    @(posedge clk); #2;
    reg_we = 1'b0; reg_addr = 3'd3;
  endtask

  task automatic rd(input int a, input string tag);
    @(posedge clk); #2;
    reg_addr = 3'(a);
    @(negedge clk);
    check(tag, int'(reg_rdata), model_read(a));
    #1 reg_addr = 3'd3;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic int mk(input int en, input int dn, input int al, input int cpe,
                            input int rpe, input int pol, input int lck);
    return en | (dn << 1) | (al << 2) | (cpe << 4) | (rpe << 5) | (pol << 6) | (lck << 7);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", int'(reg_rdata), 0);
    check("R1 pwm", int'(pwm_out), 0);
    check("R1 flags", int'(upd_flag) + int'(cmp_flag), 0);
    rd(0, "R1 ctrl");
    rd(1, "R1 reload");
    rd(2, "R1 compare");

    // R2 edge up then down
    wr(1, 7);
    wr(2, 3);
    wr(0, mk(1, 0, 0, 0, 0, 0, 0));
    run(30);
    rd(4, "R2 flags after up count");
    wr(0, mk(1, 1, 0, 0, 0, 0, 0));
    run(30);
    wr(0, 0);
    rd(4, "R8 flags held while idle");
    run(5);
    rd(4, "R8 flags still held");
    wr(4, 3);
    rd(4, "R8 flags cleared");
    check("R8 cleared value", int'(upd_flag) + int'(cmp_flag), 0);

    // R4 mode 01 with compare at the top value: never qualifies
    wr(2, 7);
    wr(5, 1);
    rd(3, "R9 count zeroed");
    wr(0, mk(1, 0, 1, 0, 0, 0, 0));
    run(40);
    check("R4 top is up phase in code 01", int'(cmp_flag), 0);
    wr(0, 0);
    wr(4, 3);

    // R3/R4 each center mode with mid compare
    for (int al = 1; al < 4; al++) begin
      wr(2, 3);
      wr(5, 1);
      wr(4, 3);
      wr(0, mk(1, 0, al, 0, 0, 0, 0));
      run(37);
      rd(4, "R4 flags center mode");
      wr(0, 0);
    end
    // R4 code 10 with compare 0: only the first zero counts
    wr(2, 0); wr(5, 1); wr(4, 3);
    wr(0, mk(1, 0, 2, 0, 0, 0, 0));
    run(40);
    rd(4, "R4 zero after restart");

    // R10 alignment frozen while enabled
    wr(0, mk(1, 0, 0, 0, 0, 0, 0));
    rd(0, "R10 align kept");
    wr(0, 0);

    // R5 compare preload
    wr(2, 2);
    wr(1, 6);
    wr(0, mk(1, 0, 3, 1, 0, 0, 0));
    run(9);
    wr(2, 5);
    rd(2, "R5 shadow read");
    run(30);
    // R6 reload preload
    wr(0, mk(1, 0, 3, 1, 1, 0, 0));
    run(4);
    wr(1, 9);
    run(40);
    rd(1, "R6 reload shadow");
    wr(0, 0);

    // R7 polarity and extreme compares
    wr(1, 5);
    wr(2, 0);
    wr(0, mk(1, 0, 0, 0, 0, 1, 0));
    run(15);
    wr(2, 9);
    run(15);
    wr(2, 2);
    wr(0, mk(1, 0, 0, 0, 0, 0, 0));
    run(15);
    // R9 command while running
    wr(5, 1);
    run(10);
    wr(0, 0);

    // R11 lock
    wr(0, mk(0, 0, 0, 1, 0, 0, 3));
    wr(0, mk(0, 0, 1, 0, 1, 0, 0));
    rd(0, "R11 preload bits locked");
    // R12 register map read back
    rd(5, "R12 command reads zero");
    rd(3, "R12 count read");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule